// File: doc/BRIEF.md
# PS/2 Receive Frame Decoder with Byte Queue

This block listens to the clock and data lines of a PS/2 device and turns each 11-bit frame into a byte. Both lines first pass through two-flop synchronizers. A decoder state machine samples the data line on every synchronized falling edge of the device clock. It checks the parity bit and the stop bit of each frame. A frame that fails a check raises a one-cycle error pulse and delivers no byte.

Each good byte goes to one of two places. In polled mode it enters a byte queue, and a consumer drains the queue through a ready/valid port. In callback mode it appears as a one-cycle strobe with the byte beside it. When the queue is full, the oldest entry gives way to the new byte and an overrun pulse is raised. Changing the mode in either direction empties the queue. While the host transmitter owns the lines, it holds `rx_enable` low, and the decoder stays idle.

The decoder has four states:
- `ST_IDLE`: waiting for a start bit.
- `ST_DATA`: collecting eight data bits.
- `ST_PARITY`: taking the parity bit.
- `ST_STOP`: taking the stop bit and judging the frame.

Its transitions are:
- IDLE→DATA on a falling edge with data low.
- DATA→DATA for bits 0 to 6.
- DATA→PARITY after bit 7.
- PARITY→STOP on the next edge.
- STOP→IDLE on the stop edge.
- Any state→IDLE on the frame timeout.
- Any state→IDLE when `rx_enable` is low.

Top module: `ps2_rx_decoder`

## Requirements
- R1: A frame is a low start bit, eight data bits least significant first, a parity bit and a stop bit, each taken on a falling clock edge. A good frame yields its data byte.
- R2: Parity is odd: the parity bit is 1 exactly when the data byte holds an even number of ones. A mismatch gives a one-cycle `err_parity` pulse and delivers no byte.
- R3: A stop bit that reads low gives a one-cycle `err_frame` pulse and delivers no byte. This check takes precedence over the parity check, so at most one outcome is reported per frame.
- R4: In polled mode (`cb_mode`=0), good bytes are read out in arrival order. `rd_data` is valid while `rd_valid` is high, and a cycle with both `rd_valid` and `rd_ready` high removes one byte.
- R5: A read attempted on an empty queue sees `rd_valid` low and removes nothing.
- R6: The queue holds `DEPTH` bytes (default 100). A byte arriving while the queue is full, with no read in that cycle, discards the oldest byte, is stored, and raises a one-cycle `err_overrun` pulse.
- R7: In callback mode (`cb_mode`=1), each good byte raises `cb_strobe` for one cycle with the byte on `cb_byte`, and nothing enters the queue.
- R8: Any change of `cb_mode` empties the queue.
- R9: A frame that has not completed within `FRAME_TIMEOUT` cycles of its start edge is dropped without any flag, and the decoder waits for a fresh start bit.
- R10: While `rx_enable` is low, the decoder is held idle, any partial frame is discarded, and edges on the lines produce no byte and no error.
- R11: After reset, `rd_valid`, `cb_strobe`, `err_parity`, `err_frame` and `err_overrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ps2_clk_in | input | 1 | Device-driven PS/2 clock line (asynchronous) |
| ps2_dat_in | input | 1 | Device-driven PS/2 data line (asynchronous) |
| rx_enable | input | 1 | Low while the host transmitter owns the lines |
| cb_mode | input | 1 | 1 selects the callback strobe, 0 selects the queue |
| cb_strobe | output | 1 | One-cycle pulse for a good byte in callback mode |
| cb_byte | output | 8 | Byte that goes with `cb_strobe` |
| rd_ready | input | 1 | Consumer takes the head byte |
| rd_valid | output | 1 | Queue is not empty |
| rd_data | output | 8 | Head byte of the queue |
| err_parity | output | 1 | Parity error pulse |
| err_frame | output | 1 | Stop-bit (framing) error pulse |
| err_overrun | output | 1 | Oldest byte discarded on overflow |

## Verification
The hardest state to reach from the ports is a full queue that is still receiving. The stimulus gets there by streaming `DEPTH`+2 frames without reading. It then drains the whole queue to show that exactly the two oldest bytes were lost and that two overrun pulses occurred. Two other cases are hard to reach: a partial frame abandoned by a stalled device clock, and a frame cut off by dropping `rx_enable`. Each is set up by driving only part of a frame by hand. A complete frame follows, and it must decode correctly, which it does only if the leftover bits were really discarded.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    localparam int BYTE_BITS = 8;
endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ps2rx_frame.sv
module ps2rx_frame
    import ps2rx_pkg::*;
#(
    parameter int FRAME_TIMEOUT = 260000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 line_clk,
    input  logic                 line_dat,
    output logic                 byte_valid,
    output logic [BYTE_BITS-1:0] byte_out,
    output logic                 err_parity,
    output logic                 err_frame
);
    localparam int TMO_W = $clog2(FRAME_TIMEOUT + 1);
    localparam int CNT_W = $clog2(BYTE_BITS);

    rx_state_t            state, nstate;
    logic                 clk_prev;
    logic                 fall;
    logic [BYTE_BITS-1:0] shreg;
    logic [CNT_W-1:0]     bitcnt;
    logic                 par_bit;
    logic [TMO_W-1:0]     tmo_cnt;
    logic                 expired;

    assign fall    = clk_prev & ~line_clk;
    assign expired = (state != ST_IDLE) && (tmo_cnt == TMO_W'(FRAME_TIMEOUT - 1));

    // next-state logic
    always_comb begin
        nstate = state;
        if (!enable || expired) begin
            nstate = ST_IDLE;
        end else if (fall) begin
            unique case (state)
                ST_IDLE:   if (!line_dat) nstate = ST_DATA;
                ST_DATA:   if (bitcnt == CNT_W'(BYTE_BITS - 1)) nstate = ST_PARITY;
                ST_PARITY: nstate = ST_STOP;
                ST_STOP:   nstate = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // frame datapath: edge history, shift register, bit counter, timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev <= 1'b1;
            shreg    <= '0;
            bitcnt   <= '0;
            par_bit  <= 1'b0;
            tmo_cnt  <= '0;
        end else begin
            clk_prev <= line_clk;
            if (!enable || state == ST_IDLE) tmo_cnt <= '0;
            else                             tmo_cnt <= tmo_cnt + 1'b1;
            if (!enable) begin
                shreg   <= '0;
                bitcnt  <= '0;
                par_bit <= 1'b0;
            end else if (fall && !expired) begin
                unique case (state)
                    ST_IDLE:   bitcnt <= '0;
                    ST_DATA: begin
                        shreg  <= {line_dat, shreg[BYTE_BITS-1:1]};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    ST_PARITY: par_bit <= line_dat;
                    ST_STOP:   bitcnt <= '0;
                endcase
            end
        end
    end

    // outputs: judge the frame on the stop edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_valid <= 1'b0;
            byte_out   <= '0;
            err_parity <= 1'b0;
            err_frame  <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            err_parity <= 1'b0;
            err_frame  <= 1'b0;
            if (enable && fall && !expired && state == ST_STOP) begin
                if (!line_dat) begin
                    err_frame <= 1'b1;
                end else if (!(^{shreg, par_bit})) begin
                    err_parity <= 1'b1;
                end else begin
                    byte_valid <= 1'b1;
                    byte_out   <= shreg;
                end
            end
        end
    end
endmodule

// File: rtl/ps2rx_fifo.sv
module ps2rx_fifo #(
    parameter int DEPTH = 100,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             not_empty,
    output logic             dropped
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             full, do_pop, evict;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign not_empty = (count != '0);
    assign full      = (count == CNT_W'(DEPTH));
    assign do_pop    = pop && not_empty;
    assign evict     = push && full && !do_pop;
    assign dout      = mem[rptr];

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            dropped <= 1'b0;
        end else if (flush) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            dropped <= 1'b0;
        end else begin
            dropped <= evict;
            if (push) wptr <= wrap_inc(wptr);
            if (do_pop || evict) rptr <= wrap_inc(rptr);
            if (push && !do_pop && !full) count <= count + 1'b1;
            else if (!push && do_pop)     count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/ps2_rx_decoder.sv
module ps2_rx_decoder
    import ps2rx_pkg::*;
#(
    parameter int DEPTH         = 100,
    parameter int FRAME_TIMEOUT = 260000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_in,
    input  logic       ps2_dat_in,
    input  logic       rx_enable,
    input  logic       cb_mode,
    output logic       cb_strobe,
    output logic [7:0] cb_byte,
    input  logic       rd_ready,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun
);
    logic                 s_clk, s_dat;
    logic                 got_byte;
    logic [BYTE_BITS-1:0] got_data;
    logic                 cb_mode_q;
    logic                 flush;

    ps2rx_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d(ps2_clk_in), .q(s_clk)
    );
    ps2rx_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d(ps2_dat_in), .q(s_dat)
    );

    ps2rx_frame #(.FRAME_TIMEOUT(FRAME_TIMEOUT)) u_frame (
        .clk(clk), .rst_n(rst_n), .enable(rx_enable),
        .line_clk(s_clk), .line_dat(s_dat),
        .byte_valid(got_byte), .byte_out(got_data),
        .err_parity(err_parity), .err_frame(err_frame)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cb_mode_q <= 1'b0;
        else        cb_mode_q <= cb_mode;
    end
    assign flush = (cb_mode_q != cb_mode);

    ps2rx_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_BITS)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(got_byte && !cb_mode), .push_data(got_data),
        .pop(rd_ready), .dout(rd_data), .not_empty(rd_valid),
        .dropped(err_overrun)
    );

    assign cb_strobe = got_byte && cb_mode;
    assign cb_byte   = got_data;
endmodule

// File: rtl/ps2rx_checker.sv
module ps2rx_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_enable,
    input logic cb_mode,
    input logic cb_strobe,
    input logic rd_valid,
    input logic err_parity,
    input logic err_frame,
    input logic err_overrun
);
    a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_parity && err_frame) && !(cb_strobe && (err_parity || err_frame)));

    a_r2_parity_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_parity |=> !err_parity);

    a_r7_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cb_strobe |=> !cb_strobe);

    a_r8_cb_queue_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (cb_mode && $past(cb_mode)) |-> !rd_valid);

    a_r6_overrun_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |-> rd_valid);

    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !(cb_strobe || err_parity || err_frame));
endmodule

bind ps2_rx_decoder ps2rx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .cb_mode(cb_mode),
    .cb_strobe(cb_strobe), .rd_valid(rd_valid), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun)
);

// File: tb/sim_ps2_rx_decoder.sv
`timescale 1ns/1ps
module sim_ps2_rx_decoder;
    localparam int DEPTH = 100;
    localparam int TMO   = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ps2_clk = 1'b1, ps2_dat = 1'b1;
    logic rx_enable = 1'b1, cb_mode = 1'b0, rd_ready = 1'b0;
    logic cb_strobe, rd_valid, err_parity, err_frame, err_overrun;
    logic [7:0] cb_byte, rd_data;

    always #2.5 clk = ~clk;

    ps2_rx_decoder #(.DEPTH(DEPTH), .FRAME_TIMEOUT(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .ps2_clk_in(ps2_clk), .ps2_dat_in(ps2_dat),
        .rx_enable(rx_enable), .cb_mode(cb_mode), .cb_strobe(cb_strobe),
        .cb_byte(cb_byte), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun)
    );

    // event kinds: 1 callback byte, 2 parity error, 3 framing error
    typedef struct packed { logic [1:0] kind; logic [7:0] data; } ev_t;
    ev_t        ev_q[$];
    logic [7:0] model_q[$];
    int checks = 0, fails = 0, ovr_seen = 0, ovr_exp = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compare produced events with the expected queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (err_overrun) ovr_seen++;
            if (cb_strobe || err_parity || err_frame) begin
                logic [1:0] k;
                ev_t e;
                k = cb_strobe ? 2'd1 : (err_parity ? 2'd2 : 2'd3);
                if (ev_q.size() == 0) begin
                    check("R1 unexpected event", {22'd0, k, cb_byte}, 32'd0);
                end else begin
                    e = ev_q.pop_front();
                    check("R2/R3/R7 event kind", {30'd0, k}, {30'd0, e.kind});
                    if (k == 2'd1) check("R7 callback byte", {24'd0, cb_byte}, {24'd0, e.data});
                end
            end
        end
    end

    task automatic dev_bit(input logic b);
        ps2_dat = b;
        repeat (10) @(posedge clk);
        ps2_clk = 1'b0;
        repeat (20) @(posedge clk);
        ps2_clk = 1'b1;
        repeat (10) @(posedge clk);
    endtask

    // driver: send a frame and record what it should produce
    task automatic send_frame(input logic [7:0] b, input logic bad_par,
                              input logic stop_b, input logic counted);
        logic par;
        par = (~^b) ^ bad_par;
        dev_bit(1'b0);
        for (int i = 0; i < 8; i++) dev_bit(b[i]);
        dev_bit(par);
        if (counted) begin
            if (!stop_b)     ev_q.push_back('{2'd3, 8'h00});
            else if (bad_par) ev_q.push_back('{2'd2, 8'h00});
            else if (cb_mode) ev_q.push_back('{2'd1, b});
            else begin
                model_q.push_back(b);
                if (model_q.size() > DEPTH) begin
                    void'(model_q.pop_front());
                    ovr_exp++;
                end
            end
        end
        dev_bit(stop_b);
        ps2_dat = 1'b1;
        repeat (10) @(posedge clk);
    endtask

    task automatic read_one(input string tag);
        @(negedge clk);
        check({tag, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
        if (model_q.size() > 0)
            check({tag, " rd_data"}, {24'd0, rd_data}, {24'd0, model_q.pop_front()});
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    task automatic check_empty(input string tag);
        @(negedge clk);
        check(tag, {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic set_cb(input logic v);
        @(negedge clk);
        cb_mode = v;
        model_q.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R11 reset outputs",
              {27'd0, rd_valid, cb_strobe, err_parity, err_frame, err_overrun}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);

        // R1 / R4: polled decode, several bit patterns, order kept
        send_frame(8'h5A, 0, 1, 1);
        send_frame(8'h00, 0, 1, 1);
        send_frame(8'hFF, 0, 1, 1);
        send_frame(8'h81, 0, 1, 1);
        read_one("R4 order");
        read_one("R1 zero byte");
        read_one("R1 all ones");
        read_one("R1 lsb first");
        check_empty("R5 empty after drain");
        // R5: reading when empty removes nothing and valid stays low
        @(negedge clk); rd_ready = 1'b1;
        @(negedge clk); rd_ready = 1'b0;
        check_empty("R5 empty read");

        // R2: parity error, byte not stored
        send_frame(8'h37, 1, 1, 1);
        check_empty("R2 bad parity not stored");
        // R3: framing error wins over parity
        send_frame(8'h42, 0, 0, 1);
        send_frame(8'h42, 1, 0, 1);
        check_empty("R3 bad stop not stored");

        // R6: overflow drops oldest
        for (int i = 0; i < DEPTH + 2; i++) send_frame(8'((i * 7 + 3) & 8'hFF), 0, 1, 1);
        check("R6 overrun pulses", ovr_seen, ovr_exp);
        for (int i = 0; i < DEPTH; i++) read_one("R6 drain");
        check_empty("R6 empty after drain");

        // R8 / R7: fill, switch to callback, queue flushed, bytes strobed
        send_frame(8'h11, 0, 1, 1);
        send_frame(8'h22, 0, 1, 1);
        set_cb(1'b1);
        check_empty("R8 flush on enable");
        send_frame(8'hA5, 0, 1, 1);
        send_frame(8'h3C, 0, 1, 1);
        check_empty("R7 callback bypasses queue");
        set_cb(1'b0);

        // R9: partial frame abandoned, next frame decodes cleanly
        dev_bit(1'b0); dev_bit(1'b1); dev_bit(1'b0); dev_bit(1'b1);
        ps2_dat = 1'b1;
        repeat (TMO + 200) @(posedge clk);
        send_frame(8'hC3, 0, 1, 1);
        read_one("R9 after timeout");
        check_empty("R9 nothing extra");

        // R10: disable mid-frame, then a full frame while disabled
        dev_bit(1'b0); dev_bit(1'b1); dev_bit(1'b1);
        rx_enable = 1'b0;
        repeat (20) @(posedge clk);
        rx_enable = 1'b1;
        ps2_dat = 1'b1;
        repeat (20) @(posedge clk);
        send_frame(8'h96, 0, 1, 1);
        read_one("R10 after re-enable");
        rx_enable = 1'b0;
        send_frame(8'h77, 0, 1, 0);
        check_empty("R10 ignored while disabled");
        rx_enable = 1'b1;

        repeat (20) @(posedge clk);
        check("R7 all expected events seen", ev_q.size(), 32'd0);
        check("R6 overrun total", ovr_seen, ovr_exp);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule